// File: doc/BRIEF.md
# Systolic Bit-Pattern Matcher

This block watches a serial stream of single bits and flags every position where the most recent bits equal a fixed pattern of 1s and 0s chosen at elaboration time. It is built as a linear chain of identical one-bit cells, and each cell holds one bit of the pattern. Input bits travel along the chain in one direction. A partial-match token travels the other way and, at each cell it passes, is ANDed with the result of an equality test.

Each input bit is presented for two clock cycles. A strobe marks the first cycle of each pair, and pairs follow one another with no gap. Because the bits and the tokens move in opposite directions, each token meets bits from the same phase of successive pairs at successive cells. No signal has to reach every cell in the same cycle. The cost is that the array runs at half the clock rate and needs more cycles before it first reports. The value on the bit input during the repeat cycle never reaches a reported result.

A matching window is reported as a one-cycle pulse in the cycle after its strobe. No pulse is raised until the array has taken in a full pattern length of bits since reset.

Top module: `systolic_pattern_match`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `match` is low.
- R2: `match` is high exactly when, for every j from 0 to N-1, the j-th most recently strobed bit (j=0 is the bit of the current strobe) equals `PATTERN[j]`, subject to R3 and R4.
- R3: A result appears on `match` in the cycle directly after the strobe cycle and lasts one cycle. In every other cycle `match` is low. `bit_valid` is high in the first cycle of each pair only, so it is never high in two consecutive cycles.
- R4: `match` stays low until at least N bits have been strobed since reset was released, even if the earlier contents of the array would otherwise form the pattern.
- R5: The value on `bit_in` in the repeat cycle that follows a strobe has no effect on any reported result.
- R6: Overlapping occurrences of the pattern are each reported, because the window slides by one bit for every strobe.
- R7: Asserting reset in the middle of a stream discards all history, and the count of R4 starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | Strobe marking the first cycle of each two-cycle bit |
| bit_in | input | 1 | Serial data bit, held for two cycles |
| match | output | 1 | One-cycle pulse when the newest N bits equal the pattern |

## Verification
The result for a bit is due one clock edge after its strobe edge. It is visible throughout the repeat cycle and has dropped again by the next strobe cycle. The bench drives inputs on falling edges. It samples `match` at the falling edge inside the repeat cycle, before it changes the input. It samples again at the falling edge of the next strobe cycle to confirm that the pulse has ended. Expected results come from a shift history of the strobed bits kept in the bench. The bench compares that history with the pattern and gates the result with its own count of bits since reset.

// File: rtl/spm_pkg.sv
// Package: shared sizing helpers for the systolic pattern matcher.
// Assumes pattern lengths of at least one bit.
package spm_pkg;

    // Width of a counter that must reach the value n.
    function automatic int unsigned spm_count_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/spm_cell.sv
// Module: spm_cell
// One systolic cell. It tests the bit arriving at this cell against its fixed
// weight and forwards the incoming token only if the test passes.
// Assumes the caller supplies the correctly delayed bit for this cell position.
module spm_cell #(
    parameter bit WEIGHT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic x_in,
    input  logic y_in,
    output logic y_out
);

    logic y_q;

    // Token register: pass the token on when the bit equals the weight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q <= 1'b0;
        end else begin
            y_q <= y_in & ~(x_in ^ WEIGHT);
        end
    end

    assign y_out = y_q;

endmodule

// File: rtl/spm_array.sv
// Module: spm_array
// Chain of N cells. Bits enter at cell 0 and move up one cell per clock.
// Tokens enter at cell N-1, where they are tied to 1, and move down one cell
// per clock. The head token therefore combines bits that are 2 cycles apart.
// Assumes the bit input is held for two cycles per bit.
module spm_array #(
    parameter int unsigned    N       = 3,
    parameter logic [N-1:0]   PATTERN = 3'b101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic y_head
);

    logic [N-1:0] x_at;
    logic [N:0]   y_link;

    assign x_at[0]   = bit_in;
    assign y_link[N] = 1'b1;

    generate
        if (N > 1) begin : g_xpipe
            logic [N-1:1] x_q;

            // Bit pipeline: each stage copies the bit seen by the cell below.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    x_q <= '0;
                end else begin
                    x_q <= x_at[N-2:0];
                end
            end

            assign x_at[N-1:1] = x_q;
        end

        for (genvar k = 0; k < N; k++) begin : g_cell
            spm_cell #(
                .WEIGHT (PATTERN[k])
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .x_in  (x_at[k]),
                .y_in  (y_link[k+1]),
                .y_out (y_link[k])
            );
        end
    endgenerate

    assign y_head = y_link[0];

endmodule

// File: rtl/spm_qualify.sv
// Module: spm_qualify
// Turns the head token into a reported result. A result is kept only in the
// cycle after a strobe, and only once N bits have been strobed since reset.
// Assumes strobes arrive exactly every second cycle while a stream runs.
module spm_qualify #(
    parameter int unsigned N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic y_head,
    output logic match
);

    localparam int unsigned CW = spm_pkg::spm_count_width(N);
    localparam logic [CW-1:0] FULL = CW'(N);

    logic [CW-1:0] seen_q;
    logic          strobe_q;

    // Strobe delay and saturating count of bits since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= bit_valid;
            if (bit_valid && (seen_q != FULL)) begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    assign match = strobe_q & y_head & (seen_q == FULL);

endmodule

// File: rtl/systolic_pattern_match.sv
// Module: systolic_pattern_match
// Top level: serial bit stream in, one-cycle match pulse out. PATTERN[j] is
// compared with the j-th most recent strobed bit, where j=0 is the newest.
// Assumes bit_valid in the first cycle of each back-to-back two-cycle pair.
module systolic_pattern_match #(
    parameter int unsigned  N       = 3,
    parameter logic [N-1:0] PATTERN = 3'b101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic match
);

    logic y_head;

    spm_array #(
        .N       (N),
        .PATTERN (PATTERN)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (bit_in),
        .y_head (y_head)
    );

    spm_qualify #(
        .N (N)
    ) u_qualify (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .y_head    (y_head),
        .match     (match)
    );

endmodule

// File: rtl/spm_checker.sv
// Module: spm_checker
// Temporal checks on the matcher's ports. It keeps its own count of strobed
// bits since reset. Attached to every matcher instance by the bind below.
module spm_checker #(
    parameter int unsigned  N       = 3,
    parameter logic [N-1:0] PATTERN = 3'b101
) (
    input logic clk,
    input logic rst_n,
    input logic bit_valid,
    input logic bit_in,
    input logic match
);

    logic [31:0] seen;

    // Independent saturating count of strobed bits since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (bit_valid && (seen < 32'(N))) begin
            seen <= seen + 32'd1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !match);                                   // R1
    AST_NEWEST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> ($past(bit_in) == PATTERN[0]));                    // R2
    AST_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> $past(bit_valid));                                 // R3
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);                                           // R3
    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);                                   // R3
    AST_ENOUGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (seen >= 32'(N)));                                 // R4

endmodule

bind systolic_pattern_match spm_checker #(
    .N       (N),
    .PATTERN (PATTERN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .match     (match)
);

// File: tb/systolic_pattern_match_tb.sv
// Bench: two matchers with N=3, patterns 101 and 001, driven by one stream.
// Expected results come from a bit history kept in the bench.
module systolic_pattern_match_tb;

    localparam logic [2:0] PAT_A = 3'b101;
    localparam logic [2:0] PAT_Z = 3'b001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic match_a;
    logic match_z;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] hist = '0;
    int nb = 0;

    always #2 clk = ~clk;

    systolic_pattern_match #(.N(3), .PATTERN(PAT_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in), .match(match_a)
    );

    systolic_pattern_match #(.N(3), .PATTERN(PAT_Z)) u_dut_z (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in), .match(match_z)
    );

    // Record one comparison and report it if it fails.
    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Expected result for a pattern from the bench history (R2, R4).
    function automatic logic expect_match(input logic [2:0] pat);
        return (nb >= 3) && (hist[2:0] == pat);
    endfunction

    // Synchronous reset of a few cycles, followed by idle cycles.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 in reset dut_a", match_a, 1'b0);
            check("R1 in reset dut_z", match_z, 1'b0);
        end
        rst_n = 1'b1;
        hist = '0;
        nb = 0;
        @(negedge clk);
        check("R1 first cycle after release dut_a", match_a, 1'b0);
        check("R1 first cycle after release dut_z", match_z, 1'b0);
    endtask

    // One bit as a strobe cycle plus a repeat cycle. With flip set, the
    // repeat cycle carries the inverted bit (R5).
    task automatic send_bit(input logic b, input logic flip, input string req);
        @(negedge clk);
        check("R3 low outside result cycle dut_a", match_a, 1'b0);
        check("R3 low outside result cycle dut_z", match_z, 1'b0);
        bit_valid = 1'b1;
        bit_in = b;
        hist = {hist[14:0], b};
        if (nb < 100) nb++;
        @(negedge clk);
        check({req, " dut_a"}, match_a, expect_match(PAT_A));
        check({req, " dut_z"}, match_z, expect_match(PAT_Z));
        bit_valid = 1'b0;
        bit_in = flip ? ~b : b;
    endtask

    initial begin
        do_reset();

        // Sweep: every 5-bit word back to back, covering all 3-bit windows
        // and overlapping hits; the repeat cycle is inverted on a mix of bits.
        for (int v = 0; v < 32; v++) begin
            for (int i = 4; i >= 0; i--) begin
                send_bit(v[i], v[0] ^ i[0], "R2 R5 R6 sweep");
            end
        end

        // Overlap 10101 on pattern 101: hits on bits 3 and 5 (R6).
        do_reset();
        send_bit(1'b1, 1'b0, "R4 R6");
        send_bit(1'b0, 1'b0, "R4 R6");
        send_bit(1'b1, 1'b0, "R6 first hit");
        send_bit(1'b0, 1'b1, "R6");
        send_bit(1'b1, 1'b1, "R6 second hit");

        // Early bits: pattern 001 would be formed from reset zeros (R4).
        do_reset();
        send_bit(1'b1, 1'b1, "R4 first bit gated");
        send_bit(1'b0, 1'b1, "R4");
        send_bit(1'b0, 1'b1, "R4");
        send_bit(1'b1, 1'b0, "R4 R2 full window hit");

        // Reset in mid-stream discards history and restarts the count (R7).
        send_bit(1'b0, 1'b0, "R7 pre");
        send_bit(1'b0, 1'b0, "R7 pre");
        do_reset();
        send_bit(1'b1, 1'b0, "R7 gated after reset");
        send_bit(1'b0, 1'b0, "R7");
        send_bit(1'b0, 1'b0, "R7");
        send_bit(1'b1, 1'b0, "R7 hit after refill");
        @(negedge clk);
        check("R3 trailing low dut_a", match_a, 1'b0);
        check("R3 trailing low dut_z", match_z, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule